// File: doc/BRIEF.md
# Serial Command Receiver with Sticky Error Lockout

This block receives 8-bit command codes over a two-wire serial link: a serial clock and a bidirectional data line. It is meant for a flash programming port. The serial clock, the data input and the mode enable are sampled in the system clock domain through a synchronizer of configurable depth.

Each received code is checked against a small fixed set of valid codes:

- A valid ordinary code produces a one-cycle strobe that carries the code.
- The error check code starts an 8-bit readout of the error byte on the data line.
- Any other code sets a sticky error flag and freezes the receiver.

Once frozen, the receiver ignores all further serial activity. The only way out is to drop the mode enable and raise it again. That exit clears the receive and lock state, but it does not clear the error flag. Software can therefore still inspect the flag afterwards. The flag is cleared by the error check command that reads it.

Top module: `pgm_cmd_rx`

## Requirements
- R1: After `rst`, `sda_oe` and `cmd_strobe` are 0. The error flag powers up as 1, so the first readout returns 0x01.
- R2: Data bits are sampled on rising serial clock edges, least significant bit first. A completed code of 0x40, 0x41 or 0x70 raises `cmd_strobe` for exactly one `clk` cycle, with `cmd_code` holding the code.
- R3: Code 0x80 starts a readout of 8 bits, least significant bit first, with each bit changed on a falling serial clock edge. Bit 0 is the error flag and bits 7..1 are 0.
- R4: `sda_oe` rises at the first falling serial clock edge after the 0x80 code. It falls after the 8th rising edge of the readout.
- R5: Executing 0x80 clears the error flag, so the next readout returns 0x00 unless a new error occurs.
- R6: Any code other than 0x40, 0x41, 0x70 or 0x80 sets the error flag and locks the receiver. While locked, no strobe is produced and `sda_oe` stays 0, even when 0x80 is sent.
- R7: Dropping `prog_en` clears the bit count, any readout and the lock. The error flag is kept.
- R8: If `prog_en` drops in the same cycle that completes a code, the code is discarded and the error flag is unchanged.
- R9: While `prog_en` is low, serial activity is ignored and does not disturb the bit count of the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| prog_en | input | 1 | Serial programming mode enable (asynchronous, synchronized) |
| sclk | input | 1 | Serial clock (asynchronous, synchronized) |
| sda_in | input | 1 | Serial data from the line |
| sda_out | output | 1 | Serial data to the line |
| sda_oe | output | 1 | Drive enable for the data line |
| cmd_strobe | output | 1 | One-cycle pulse for a valid ordinary command |
| cmd_code | output | 8 | Code of the last strobed command |

## Verification
Decoding of the eighth command bit and the mode-exit reset can occur in the same `clk` cycle. The mode-exit reset must win. The bench provokes this by dropping `prog_en` at the same instant as the final rising serial clock edge of an invalid code. Because both inputs pass through synchronizers of equal depth, the two events reach the core in one cycle. The outcome is judged after re-entering the mode. The flag had been cleared beforehand, so a readout of 0x00 shows that the invalid code was discarded.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_ERRCHK = 8'h80;
  localparam int N_PLAIN = 3;
  localparam logic [CODE_W-1:0] PLAIN_CODES [N_PLAIN] = '{8'h40, 8'h41, 8'h70};

  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_TX   = 2'd1,
    ST_LOCK = 2'd2
  } rx_state_t;
endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= din;
  end

  genvar i;
  generate
    for (i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/pgm_rx_shift.sv
module pgm_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic         done,
  output logic [W-1:0] code
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  assign done = shift && (cnt == CW'(W - 1));
  assign code = {bit_in, sh[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh  <= '0;
      cnt <= '0;
    end else if (shift) begin
      sh  <= code;
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgm_tx_shift.sv
module pgm_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         fall,
  input  logic         rise,
  output logic         sda_out,
  output logic         sda_oe,
  output logic         finished
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  buf_q;
  logic [CW-1:0] cnt;
  logic          armed;

  assign finished = rise && sda_oe && (cnt == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      buf_q   <= '0;
      cnt     <= '0;
      armed   <= 1'b0;
      sda_out <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (load) begin
      buf_q <= load_val;
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (fall) begin
        sda_out <= buf_q[0];
        buf_q   <= buf_q >> 1;
        sda_oe  <= 1'b1;
      end else if (rise && sda_oe) begin
        if (finished) begin
          sda_oe <= 1'b0;
          armed  <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pgm_cmd_rx.sv
module pgm_cmd_rx
  import pgm_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic ERR_INIT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic              sclk,
  input  logic              sda_in,
  output logic              sda_out,
  output logic              sda_oe,
  output logic              cmd_strobe,
  output logic [CODE_W-1:0] cmd_code
);
  logic [2:0] sync_q;
  logic       en_s, sclk_s, sda_s, sclk_d;
  logic       rise, fall;

  pgm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({prog_en, sclk, sda_in}),
    .dout(sync_q)
  );
  assign {en_s, sclk_s, sda_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end
  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  rx_state_t         state;
  logic              err_flag;
  logic              locked;
  logic              rx_done;
  logic [CODE_W-1:0] rx_code;
  logic              tx_done;
  logic              is_chk, is_plain;
  logic [N_PLAIN-1:0] hit;

  assign locked = (state == ST_LOCK);

  pgm_rx_shift #(.W(CODE_W)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .clr   (!en_s || state != ST_RX),
    .shift (en_s && state == ST_RX && rise),
    .bit_in(sda_s),
    .done  (rx_done),
    .code  (rx_code)
  );

  genvar k;
  generate
    for (k = 0; k < N_PLAIN; k++) begin : g_match
      assign hit[k] = (rx_code == PLAIN_CODES[k]);
    end
  endgenerate
  assign is_plain = |hit;
  assign is_chk   = (rx_code == CODE_ERRCHK);

  pgm_tx_shift #(.W(CODE_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .clr     (!en_s),
    .load    (en_s && state == ST_RX && rx_done && is_chk),
    .load_val({{(CODE_W-1){1'b0}}, err_flag}),
    .fall    (fall),
    .rise    (rise),
    .sda_out (sda_out),
    .sda_oe  (sda_oe),
    .finished(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RX;
      err_flag   <= ERR_INIT;
      cmd_strobe <= 1'b0;
      cmd_code   <= '0;
    end else begin
      cmd_strobe <= 1'b0;
      if (!en_s) begin
        state <= ST_RX;
      end else begin
        unique case (state)
          ST_RX: if (rx_done) begin
            if (is_chk) begin
              state    <= ST_TX;
              err_flag <= 1'b0;
            end else if (is_plain) begin
              cmd_strobe <= 1'b1;
              cmd_code   <= rx_code;
            end else begin
              err_flag <= 1'b1;
              state    <= ST_LOCK;
            end
          end
          ST_TX:   if (tx_done) state <= ST_RX;
          ST_LOCK: state <= ST_LOCK;
          default: state <= ST_RX;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgm_cmd_rx_chk.sv
module pgm_cmd_rx_chk
  import pgm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              en_s,
  input logic              locked,
  input logic              err_flag,
  input logic              sda_oe,
  input logic              cmd_strobe,
  input logic [CODE_W-1:0] cmd_code
);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |=> !cmd_strobe);

  a_r2_strobe_code_valid: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> (cmd_code == PLAIN_CODES[0] || cmd_code == PLAIN_CODES[1] ||
                    cmd_code == PLAIN_CODES[2]));

  a_r5_flag_cleared_at_readout: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !err_flag);

  a_r6_lock_implies_flag: assert property (@(posedge clk) disable iff (rst)
    locked |-> err_flag);

  a_r6_locked_quiet: assert property (@(posedge clk) disable iff (rst)
    locked |-> (!sda_oe && !cmd_strobe));

  a_r7_exit_releases: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> (!locked && !sda_oe));

  a_r7_exit_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (!en_s && err_flag) |=> err_flag);
endmodule

bind pgm_cmd_rx pgm_cmd_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_s      (en_s),
  .locked    (locked),
  .err_flag  (err_flag),
  .sda_oe    (sda_oe),
  .cmd_strobe(cmd_strobe),
  .cmd_code  (cmd_code)
);

// File: tb/sim_pgm_cmd_rx.sv
module sim_pgm_cmd_rx;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_en = 1'b0;
  logic       sclk = 1'b1;
  logic       sda_in = 1'b0;
  logic       sda_out, sda_oe, cmd_strobe;
  logic [7:0] cmd_code;

  int vectors = 0;
  int errors  = 0;
  int strobes = 0;
  logic [7:0] last_code = '0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  pgm_cmd_rx u0 (
    .clk(clk), .rst(rst), .prog_en(prog_en), .sclk(sclk), .sda_in(sda_in),
    .sda_out(sda_out), .sda_oe(sda_oe), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
  );

  always @(negedge clk) if (!rst && cmd_strobe) begin
    strobes++;
    last_code = cmd_code;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; sda_in = v[i]; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    send_bits(v, 8);
  endtask

  task automatic read_byte(output logic [7:0] v, output bit oe_ok);
    oe_ok = 1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; wait_clk(HALF);
      v[i] = sda_out;
      if (!sda_oe) oe_ok = 0;
      sclk = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic reenter();
    prog_en = 1'b0; wait_clk(10);
    prog_en = 1'b1; wait_clk(10);
  endtask

  task automatic err_check(input logic [7:0] exp, input string req);
    logic [7:0] v; bit ok;
    send_byte(8'h80);
    read_byte(v, ok);
    check(ok, {req, " R4 oe during readout"}, ok, 1);
    check(v == exp, {req, " R3 error byte"}, v, exp);
    wait_clk(6);
    check(!sda_oe, "R4 oe released after 8th rise", sda_oe, 0);
  endtask

  task automatic t_reset();
    check(!sda_oe && !cmd_strobe, "R1 outputs after reset", {sda_oe, cmd_strobe}, 0);
    reenter();
    err_check(8'h01, "R1 power-on flag");
    err_check(8'h00, "R5 flag cleared");
  endtask

  task automatic t_plain();
    logic [7:0] codes [3] = '{8'h40, 8'h41, 8'h70};
    foreach (codes[i]) begin
      int s0 = strobes;
      send_byte(codes[i]);
      wait_clk(6);
      check(strobes == s0 + 1, "R2 strobe count", strobes - s0, 1);
      check(last_code == codes[i], "R2 strobed code", last_code, codes[i]);
    end
    err_check(8'h00, "R2 no error from valid codes");
  endtask

  task automatic t_lock();
    logic [7:0] v; bit ok;
    int s0;
    send_byte(8'h55);
    wait_clk(6);
    s0 = strobes;
    send_byte(8'h80);
    read_byte(v, ok);
    check(!sda_oe && !ok, "R6 no readout while locked", sda_oe, 0);
    send_byte(8'h40);
    wait_clk(6);
    check(strobes == s0, "R6 no strobe while locked", strobes - s0, 0);
    reenter();
    err_check(8'h01, "R7 flag kept through exit");
    err_check(8'h00, "R5 flag cleared after exit");
  endtask

  task automatic t_collision();
    send_bits(8'hC3, 7);
    sclk = 1'b0; sda_in = 1'b1; wait_clk(HALF);
    sclk = 1'b1; prog_en = 1'b0;
    wait_clk(12);
    prog_en = 1'b1; wait_clk(10);
    err_check(8'h00, "R8 discarded at exit");
  endtask

  task automatic t_disabled();
    int s0 = strobes;
    prog_en = 1'b0; wait_clk(4);
    send_bits(8'h40, 5);
    prog_en = 1'b1; wait_clk(10);
    send_byte(8'h41);
    wait_clk(6);
    check(strobes == s0 + 1, "R9 one strobe after enable", strobes - s0, 1);
    check(last_code == 8'h41, "R9 clean framing", last_code, 8'h41);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    t_reset();
    t_plain();
    t_lock();
    t_collision();
    t_disabled();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule